// File: doc/BRIEF.md
# USB Control Endpoint Handshake Arbiter

This block chooses the handshake that a USB device returns for one control endpoint and keeps the endpoint's interrupt flags. The packet layer hands it one received packet at a time: a token kind, a strobe, and a CRC-good indication. It also supplies a retry request and whether a receive bank is free. The block answers with a registered handshake code and updates the flags in the same clock edge.

Firmware has no read path into the block. It uses plain strobes instead: a write-one-to-clear mask over the five flags, and set or clear pulses for the stall request. Clearing the received-OUT flag hands the bank back to hardware. Clearing the transmit-ready flag commits the loaded IN packet for sending.

The packet input has no back-pressure. A strobe is accepted in every cycle, and one handshake decision is made for each strobe. Serial bit handling, CRC computation, buffering and enumeration software all belong to other blocks.

Top module: `usbcep_top`

## Requirements
- R1: A good packet with token SETUP (code 3) is answered with ACK (code 0) in every case, whatever the stall request, retry or bank state.
- R2: A good SETUP sets rx_setup (status bit 0) and clears both the stall request (bit 5) and the stalled flag (bit 4).
- R3: A good SETUP never sets rx_out (status bit 1).
- R4: For a good OUT (code 1) or IN (code 2) with retry_req high, the answer is NAK (code 1), even when a stall is requested.
- R5: For a good OUT or IN with the stall request set and no retry, the answer is STALL (code 2), and the stalled flag (bit 4) is set.
- R6: A good OUT is answered with ACK and sets rx_out only when rx_out is clear and bank_free is high. Otherwise it is answered with NAK and no flag changes.
- R7: tx_ready (bit 2) resets to 1. A good IN while tx_ready is set is answered with NAK and sets nak_in (bit 3). A good IN after firmware has cleared tx_ready is answered with ACK and sets tx_ready again.
- R8: A packet with pkt_crc_ok low, or with token code 0, produces no handshake (hs_valid low) and changes no flag.
- R9: ep_status bits 6 and 7 are the FIFO-control and read/write-allowed positions. Both always read as 0.
- R10: If a hardware set and a firmware clear hit the same flag in the same cycle, the set wins. A clear with no set in that cycle clears the flag.
- R11: A good SETUP in the same cycle as fw_stall_set leaves the stall request cleared.
- R12: After reset, hs_valid is 0 and ep_status is 8'h04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | One-cycle strobe: a packet finished |
| pkt_token | input | 2 | Token kind: 1 OUT, 2 IN, 3 SETUP, 0 none |
| pkt_crc_ok | input | 1 | Packet CRC was good |
| retry_req | input | 1 | Packet layer requires a retry |
| bank_free | input | 1 | A receive bank is free for OUT data |
| fw_flag_clr | input | 5 | Write-one-to-clear mask over status bits 4:0 |
| fw_stall_set | input | 1 | Firmware requests STALL |
| fw_stall_clr | input | 1 | Firmware withdraws the STALL request |
| hs_valid | output | 1 | A handshake is to be sent |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| irq_flags | output | 5 | Interrupt flags, same as ep_status[4:0] |
| ep_status | output | 8 | {rw_allowed 0, fifo_ctl 0, stall_req, stalled, nak_in, tx_ready, rx_out, rx_setup} |

## Verification
Each result is registered once. The handshake and every flag change for a strobe appear at the first rising edge after the strobe is driven, and a firmware strobe takes effect at that same edge. The bench drives all inputs on the falling edge and releases them on the next falling edge. It then samples outputs there, half a cycle after the edge that captured the result. Same-cycle races are formed by driving the firmware strobe in the same cycle as the packet strobe.

// File: rtl/usbcep_pkg.sv
package usbcep_pkg;
  typedef enum logic [1:0] {
    TOK_NONE  = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_IN    = 2'd2,
    TOK_SETUP = 2'd3
  } tok_e;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2,
    HS_NONE  = 2'd3
  } hs_e;

  localparam int NFLAG      = 5;
  localparam int FL_SETUP   = 0;
  localparam int FL_OUT     = 1;
  localparam int FL_TXRDY   = 2;
  localparam int FL_NAKIN   = 3;
  localparam int FL_STALLED = 4;
  localparam int ST_STALLRQ = 5;
  localparam int STATUS_W   = 8;
  localparam logic [NFLAG-1:0] FLAG_RST = 5'b00100;

  typedef struct packed {
    logic [NFLAG-1:0] set;     // hardware set per flag
    logic             clr_stl; // SETUP cancels stall request and stalled flag
    logic             send;    // a handshake is produced
    hs_e              hs;
  } decision_t;
endpackage

// File: rtl/usbcep_arbiter.sv
module usbcep_arbiter
  import usbcep_pkg::*;
(
  input  logic             pkt_valid,
  input  logic [1:0]       pkt_token,
  input  logic             pkt_crc_ok,
  input  logic             retry_req,
  input  logic             bank_free,
  input  logic             stall_req,
  input  logic [NFLAG-1:0] flags_q,
  output decision_t        dec
);
  tok_e tok;
  logic good;

  assign tok  = tok_e'(pkt_token);
  assign good = pkt_valid && pkt_crc_ok;

  always_comb begin
    dec         = '0;
    dec.hs      = HS_NONE;
    if (good) begin
      unique case (tok)
        TOK_SETUP: begin
          dec.send          = 1'b1;
          dec.hs            = HS_ACK;
          dec.set[FL_SETUP] = 1'b1;
          dec.clr_stl       = 1'b1;
        end
        TOK_OUT, TOK_IN: begin
          dec.send = 1'b1;
          if (retry_req) begin
            dec.hs = HS_NAK;
            if (tok == TOK_IN) dec.set[FL_NAKIN] = 1'b1;
          end else if (stall_req) begin
            dec.hs              = HS_STALL;
            dec.set[FL_STALLED] = 1'b1;
          end else if (tok == TOK_OUT) begin
            if (!flags_q[FL_OUT] && bank_free) begin
              dec.hs          = HS_ACK;
              dec.set[FL_OUT] = 1'b1;
            end else begin
              dec.hs = HS_NAK;
            end
          end else begin
            if (flags_q[FL_TXRDY]) begin
              dec.hs            = HS_NAK;
              dec.set[FL_NAKIN] = 1'b1;
            end else begin
              dec.hs            = HS_ACK;
              dec.set[FL_TXRDY] = 1'b1;
            end
          end
        end
        default: dec.send = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/usbcep_flag.sv
module usbcep_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= RST_VAL;
    else if (set_i) q <= 1'b1;   // a new event beats a same-cycle clear
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/usbcep_flagbank.sv
module usbcep_flagbank
  import usbcep_pkg::*;
#(
  parameter int               N       = NFLAG,
  parameter logic [N-1:0]     RST_VEC = FLAG_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    usbcep_flag #(.RST_VAL(RST_VEC[i])) u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_i[i]),
      .clr_i(clr_i[i]),
      .q    (q[i])
    );
  end
endmodule

// File: rtl/usbcep_top.sv
module usbcep_top
  import usbcep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [1:0]       pkt_token,
  input  logic             pkt_crc_ok,
  input  logic             retry_req,
  input  logic             bank_free,
  input  logic [NFLAG-1:0] fw_flag_clr,
  input  logic             fw_stall_set,
  input  logic             fw_stall_clr,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic [NFLAG-1:0] irq_flags,
  output logic [STATUS_W-1:0] ep_status
);
  decision_t        dec;
  logic [NFLAG-1:0] flags_q;
  logic [NFLAG-1:0] clr_vec;
  logic             stall_req_q;

  usbcep_arbiter u_arb (
    .pkt_valid (pkt_valid),
    .pkt_token (pkt_token),
    .pkt_crc_ok(pkt_crc_ok),
    .retry_req (retry_req),
    .bank_free (bank_free),
    .stall_req (stall_req_q),
    .flags_q   (flags_q),
    .dec       (dec)
  );

  // SETUP clears stalled together with firmware write-one-to-clear
  always_comb begin
    clr_vec = fw_flag_clr;
    if (dec.clr_stl) clr_vec[FL_STALLED] = 1'b1;
  end

  usbcep_flagbank #(.N(NFLAG), .RST_VEC(FLAG_RST)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(dec.set),
    .clr_i(clr_vec),
    .q    (flags_q)
  );

  // a SETUP cancels the stall request, even against a same-cycle firmware set
  always_ff @(posedge clk) begin
    if (!rst_n)            stall_req_q <= 1'b0;
    else if (dec.clr_stl)  stall_req_q <= 1'b0;
    else if (fw_stall_set) stall_req_q <= 1'b1;
    else if (fw_stall_clr) stall_req_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      hs_valid <= dec.send;
      hs_code  <= dec.hs;
    end
  end

  assign irq_flags = flags_q;
  assign ep_status = {2'b00, stall_req_q, flags_q};
endmodule

// File: rtl/usbcep_chk.sv
module usbcep_chk
  import usbcep_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic [1:0]       pkt_token,
  input logic             pkt_crc_ok,
  input logic             retry_req,
  input logic             hs_valid,
  input logic [1:0]       hs_code,
  input logic [STATUS_W-1:0] ep_status
);
  logic good_setup, good_data;
  assign good_setup = pkt_valid && pkt_crc_ok && (pkt_token == TOK_SETUP);
  assign good_data  = pkt_valid && pkt_crc_ok &&
                      ((pkt_token == TOK_OUT) || (pkt_token == TOK_IN));

  // R1
  setup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_setup |=> (hs_valid && hs_code == HS_ACK));

  // R2
  setup_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_setup |=> (ep_status[0] && !ep_status[4] && !ep_status[5]));

  // R3
  setup_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_setup |=> !$rose(ep_status[1]));

  // R4
  retry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_data && retry_req) |=> (hs_valid && hs_code == HS_NAK));

  // R5
  stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == HS_STALL) |-> ep_status[4]);

  // R8
  bad_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_crc_ok) |=> !hs_valid);
endmodule

bind usbcep_top usbcep_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_valid (pkt_valid),
  .pkt_token (pkt_token),
  .pkt_crc_ok(pkt_crc_ok),
  .retry_req (retry_req),
  .hs_valid  (hs_valid),
  .hs_code   (hs_code),
  .ep_status (ep_status)
);

// File: tb/usbcep_top_test.sv
module usbcep_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_valid = 1'b0;
  logic [1:0] pkt_token = 2'd0;
  logic       pkt_crc_ok = 1'b0;
  logic       retry_req = 1'b0;
  logic       bank_free = 1'b1;
  logic [4:0] fw_flag_clr = 5'd0;
  logic       fw_stall_set = 1'b0;
  logic       fw_stall_clr = 1'b0;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic [4:0] irq_flags;
  logic [7:0] ep_status;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [1:0] OUT = 2'd1, IN = 2'd2, SETUP = 2'd3;
  localparam logic [1:0] ACK = 2'd0, NAK = 2'd1, STALL = 2'd2;

  usbcep_top uut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_token(pkt_token),
    .pkt_crc_ok(pkt_crc_ok), .retry_req(retry_req), .bank_free(bank_free),
    .fw_flag_clr(fw_flag_clr), .fw_stall_set(fw_stall_set),
    .fw_stall_clr(fw_stall_clr), .hs_valid(hs_valid), .hs_code(hs_code),
    .irq_flags(irq_flags), .ep_status(ep_status)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs sampled at the following falling edge
  task automatic cyc(input logic v, input logic [1:0] tok, input logic crc,
                     input logic rty, input logic [4:0] clr,
                     input logic sset, input logic sclr);
    @(negedge clk);
    pkt_valid = v; pkt_token = tok; pkt_crc_ok = crc; retry_req = rty;
    fw_flag_clr = clr; fw_stall_set = sset; fw_stall_clr = sclr;
    @(negedge clk);
    pkt_valid = 0; pkt_token = 0; pkt_crc_ok = 0; retry_req = 0;
    fw_flag_clr = 0; fw_stall_set = 0; fw_stall_clr = 0;
  endtask

  task automatic pkt(input logic [1:0] tok);
    cyc(1'b1, tok, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0);
  endtask

  task automatic fw(input logic [4:0] clr, input logic sset, input logic sclr);
    cyc(1'b0, 2'd0, 1'b0, 1'b0, clr, sset, sclr);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 hs_valid", {7'd0, hs_valid}, 8'h00);
    chk("R12 status", ep_status, 8'h04);
    chk("R9 reserved bits", {6'd0, ep_status[7:6]}, 8'h00);
  endtask

  task automatic t_out;
    bank_free = 1;
    pkt(OUT);
    chk("R6 out ack", {6'd0, hs_code}, {6'd0, ACK});
    chk("R6 rx_out set", ep_status, 8'h06);
    pkt(OUT);
    chk("R6 out nak held", {7'd0, hs_valid, hs_code} , {5'd0, 1'b1, NAK});
    fw(5'b00010, 0, 0);
    chk("R6 rx_out cleared", ep_status, 8'h04);
    bank_free = 0;
    pkt(OUT);
    chk("R6 out nak no bank", {6'd0, hs_code}, {6'd0, NAK});
    chk("R6 no flag", ep_status, 8'h04);
    bank_free = 1;
    pkt(OUT);
    chk("R6 out ack again", {6'd0, hs_code}, {6'd0, ACK});
    fw(5'b00010, 0, 0);
  endtask

  task automatic t_in;
    pkt(IN);
    chk("R7 in nak", {6'd0, hs_code}, {6'd0, NAK});
    chk("R7 nak_in set", ep_status, 8'h0C);
    fw(5'b01100, 0, 0);
    chk("R7 committed", ep_status, 8'h00);
    pkt(IN);
    chk("R7 in ack", {6'd0, hs_code}, {6'd0, ACK});
    chk("R7 tx_ready back", ep_status, 8'h04);
  endtask

  task automatic t_stall;
    fw(5'd0, 1, 0);
    chk("R5 stall req", ep_status, 8'h24);
    pkt(OUT);
    chk("R5 stall sent", {6'd0, hs_code}, {6'd0, STALL});
    chk("R5 stalled flag", ep_status, 8'h34);
    cyc(1, IN, 1, 1, 5'd0, 0, 0);
    chk("R4 retry beats stall", {6'd0, hs_code}, {6'd0, NAK});
    chk("R4 nak_in on retry", ep_status, 8'h3C);
    pkt(SETUP);
    chk("R1 setup ack", {7'd0, hs_valid, hs_code}, {5'd0, 1'b1, ACK});
    chk("R2 R3 setup flags", ep_status, 8'h0D);
    fw(5'b01001, 0, 0);
    bank_free = 0;
    pkt(SETUP);
    chk("R1 setup ack no bank", {6'd0, hs_code}, {6'd0, ACK});
    chk("R3 rx_out clear", {7'd0, ep_status[1]}, 8'h00);
    bank_free = 1;
    fw(5'b00001, 0, 0);
  endtask

  task automatic t_bad;
    cyc(1, OUT, 0, 0, 5'd0, 0, 0);
    chk("R8 bad crc no hs", {7'd0, hs_valid}, 8'h00);
    chk("R8 bad crc no flag", ep_status, 8'h04);
    pkt(2'd0);
    chk("R8 null token", {7'd0, hs_valid}, 8'h00);
    cyc(1, IN, 0, 0, 5'd0, 0, 0);
    chk("R8 bad in no flag", ep_status, 8'h04);
  endtask

  task automatic t_race;
    pkt(IN);
    chk("R10 nak_in first", ep_status, 8'h0C);
    cyc(1, IN, 1, 0, 5'b01000, 0, 0);
    chk("R10 set wins", ep_status, 8'h0C);
    fw(5'b01000, 0, 0);
    chk("R10 clear alone", ep_status, 8'h04);
    cyc(1, SETUP, 1, 0, 5'd0, 1, 0);
    chk("R11 setup beats stall set", {7'd0, ep_status[5]}, 8'h00);
    chk("R9 reserved after all", {6'd0, ep_status[7:6]}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_out();
    t_in();
    t_stall();
    t_bad();
    t_race();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule